// File: doc/BRIEF.md
# SD card data transfer sequencer

This block governs the data phase of an SD/MMC host. Software writes one control word that picks the operation (busy check, block read or block write), the bus width, the transfer unit size, an optional burst-of-four request, the block count and whether the transfer should wait for a command-path event. Setting the launch bit in that word starts the operation. The launch bit clears itself one cycle later.

When launched, the sequencer either starts at once or parks in a waiting state. It leaves that state when the command path reports that the command has gone out (for reads and busy checks) or that the response has come back (for writes). While running, it raises one activity strobe for the data-line engine. In block mode it counts down the blocks the data path reports as finished. When the work is complete it pulses `done` and raises `irq` for a short or a long period. In stream mode the transfer runs until software writes the idle operation code.

The control word layout (bit positions): op code [1:0] (00 idle, 01 busy check, 10 receive, 11 transmit), launch [2], stream [3], wide bus [4], receive waits for command sent [5], busy check waits for command sent [6], transmit waits for response [7], unit size [9:8] (00 byte, 01 halfword, 10 word, 11 reserved), burst-of-four [10], long interrupt [11], block count [23:12].

Top module: `sd_data_seq`

## Requirements
- R1: After reset all activity strobes, `done`, `irq` and `burst4_req_en` are 0, `blk_left` is 0 and `reg_rdata` reads 0.
- R2: A write with launch bit [2] set and a non-zero op code reads back with bit [2] = 1 for exactly one cycle and then 0. The operation is launched on the following clock edge.
- R3: While running, op code 01 drives only `busy_act`, 10 drives only `rx_act` and 11 drives only `tx_act`. At most one strobe is high at any time.
- R4: With bit [5] set and op 10, reception waits after launch until a `cmd_sent` pulse, and `rsp_rcvd` does not release it. With bit [5] clear, reception starts at launch.
- R5: With bit [6] set and op 01, the busy check waits until a `cmd_sent` pulse. With bit [6] clear, it starts at launch.
- R6: With bit [7] set and op 11, transmission waits until an `rsp_rcvd` pulse, and `cmd_sent` does not release it. With bit [7] clear, it starts at launch.
- R7: In block mode (bit [3] = 0), `blk_left` loads the 12-bit count at launch and drops by one on each `blk_done` pulse while receiving or transmitting. The pulse that brings it to zero ends the transfer with `done`. A launch with count 0 ends at once with `done`.
- R8: In stream mode (bit [3] = 1), `blk_done` pulses change neither `blk_left` nor the activity strobe, and no `done` is produced.
- R9: A write with op code 00 aborts any operation, so that all strobes are 0 after the next edge. No `done` is produced.
- R10: `lane_en` is all ones when bit [4] is set and only bit 0 when it is clear.
- R11: A written size code 11 is stored and read back as 00 (byte). `burst4_req_en` is 1 only when bit [10] is set and the stored size is 10 (word).
- R12: `irq` rises together with `done` and stays high for 2 cycles when bit [11] is 0, or for IRQ_LONG (default 6) cycles when it is 1.
- R13: A write with a non-zero op code while an operation is launched, waiting or running is ignored. Op code, fields and strobes are left unchanged.
- R14: A running busy check ends on a `busy_end` pulse, which gives `done` and drops `busy_act`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 24 | Control word write data |
| reg_rdata | output | 24 | Control word read-back |
| cmd_sent | input | 1 | Command path: command transmitted pulse |
| rsp_rcvd | input | 1 | Command path: response received pulse |
| blk_done | input | 1 | Data path: one block finished pulse |
| busy_end | input | 1 | Data path: card busy released pulse |
| busy_act | output | 1 | Busy check running |
| rx_act | output | 1 | Reception running |
| tx_act | output | 1 | Transmission running |
| lane_en | output | 4 | Data line enables |
| xfer_size | output | 2 | Stored transfer unit size |
| burst4_req_en | output | 1 | Burst-of-four DMA requests permitted |
| blk_left | output | 12 | Blocks remaining |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Completion interrupt |

## Verification
On every cycle the assertions check these properties: the launch bit clears itself, the strobes are mutually exclusive, an abort forces idle, a waiting read or write is held until its own event arrives, the block count stays fixed except on a launch or a block pulse, burst requests appear only with word size, and `irq` accompanies `done`. Some behaviour can only be shown by the bench's scenarios: the exact count sequence down to completion, the interrupt lengths of 2 and IRQ_LONG cycles, the completion at once with a zero count, the normalisation of the reserved size, and the rejection of a write made mid-transfer.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;
  localparam int CNT_W     = 12;
  localparam int F_MODE_LO = 0;
  localparam int F_START   = 2;
  localparam int F_STREAM  = 3;
  localparam int F_WIDE    = 4;
  localparam int F_WRX     = 5;
  localparam int F_WBSY    = 6;
  localparam int F_WTX     = 7;
  localparam int F_SIZE_LO = 8;
  localparam int F_BURST   = 10;
  localparam int F_IRQX    = 11;
  localparam int F_CNT_LO  = 12;
  localparam int CTRL_W    = F_CNT_LO + CNT_W;

  typedef enum logic [1:0] {MODE_NONE = 2'b00, MODE_BUSY = 2'b01,
                            MODE_RX = 2'b10, MODE_TX = 2'b11} mode_e;
  typedef enum logic [1:0] {SZ_BYTE = 2'b00, SZ_HALF = 2'b01,
                            SZ_WORD = 2'b10, SZ_RSVD = 2'b11} size_e;
  typedef enum logic [1:0] {ST_IDLE = 2'b00, ST_WAIT = 2'b01,
                            ST_RUN = 2'b10} state_e;

  typedef struct packed {
    logic  irq_ext;
    logic  burst;
    size_e size;
    logic  w_tx;
    logic  w_busy;
    logic  w_rx;
    logic  wide;
    logic  stream;
  } cfg_t;

  // Reserved size code falls back to byte.
  function automatic size_e norm_size(input logic [1:0] raw);
    return (raw == SZ_RSVD) ? SZ_BYTE : size_e'(raw);
  endfunction

  // Does this op code, with these options, park in the wait state?
  function automatic logic wait_needed(input mode_e m, input cfg_t c);
    case (m)
      MODE_RX:   return c.w_rx;
      MODE_BUSY: return c.w_busy;
      MODE_TX:   return c.w_tx;
      default:   return 1'b0;
    endcase
  endfunction

  // Event that releases a parked operation.
  function automatic logic wake_event(input mode_e m, input logic cmd_ev,
                                      input logic rsp_ev);
    case (m)
      MODE_RX, MODE_BUSY: return cmd_ev;
      MODE_TX:            return rsp_ev;
      default:            return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/sdseq_regs.sv
module sdseq_regs
  import sdseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              fsm_idle,
  output mode_e             mode,
  output cfg_t              cfg,
  output logic [CNT_W-1:0]  cnt_init,
  output logic              start_q,
  output logic              abort,
  output logic [CTRL_W-1:0] rdata
);
  mode_e wmode;
  logic  accept;

  assign wmode  = mode_e'(wdata[F_MODE_LO +: 2]);
  assign abort  = we && (wmode == MODE_NONE);
  assign accept = we && ((fsm_idle && !start_q) || abort);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= MODE_NONE;
      cfg      <= '0;
      cnt_init <= '0;
      start_q  <= 1'b0;
    end else if (accept) begin
      mode        <= wmode;
      cfg.stream  <= wdata[F_STREAM];
      cfg.wide    <= wdata[F_WIDE];
      cfg.w_rx    <= wdata[F_WRX];
      cfg.w_busy  <= wdata[F_WBSY];
      cfg.w_tx    <= wdata[F_WTX];
      cfg.size    <= norm_size(wdata[F_SIZE_LO +: 2]);
      cfg.burst   <= wdata[F_BURST];
      cfg.irq_ext <= wdata[F_IRQX];
      cnt_init    <= wdata[F_CNT_LO +: CNT_W];
      start_q     <= wdata[F_START] && (wmode != MODE_NONE);
    end else begin
      start_q <= 1'b0;
    end
  end

  always_comb begin
    rdata                    = '0;
    rdata[F_MODE_LO +: 2]    = mode;
    rdata[F_START]           = start_q;
    rdata[F_STREAM]          = cfg.stream;
    rdata[F_WIDE]            = cfg.wide;
    rdata[F_WRX]             = cfg.w_rx;
    rdata[F_WBSY]            = cfg.w_busy;
    rdata[F_WTX]             = cfg.w_tx;
    rdata[F_SIZE_LO +: 2]    = cfg.size;
    rdata[F_BURST]           = cfg.burst;
    rdata[F_IRQX]            = cfg.irq_ext;
    rdata[F_CNT_LO +: CNT_W] = cnt_init;
  end
endmodule

// File: rtl/sdseq_fsm.sv
module sdseq_fsm
  import sdseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_q,
  input  logic   abort,
  input  mode_e  mode,
  input  logic   stream,
  input  logic   hold,
  input  logic   cnt_zero,
  input  logic   last_blk,
  input  logic   cmd_sent,
  input  logic   rsp_rcvd,
  input  logic   blk_done,
  input  logic   busy_end,
  output state_e state,
  output logic   launch,
  output logic   finish,
  output logic   blk_step
);
  state_e nxt;
  logic   data_mode;
  logic   wake;

  assign data_mode = (mode == MODE_RX) || (mode == MODE_TX);
  assign wake      = wake_event(mode, cmd_sent, rsp_rcvd);

  always_comb begin
    nxt      = state;
    finish   = 1'b0;
    blk_step = 1'b0;
    launch   = start_q && !abort;
    case (state)
      ST_IDLE: begin
        if (launch) begin
          if (data_mode && !stream && cnt_zero) finish = 1'b1;
          else if (hold)                        nxt    = ST_WAIT;
          else                                  nxt    = ST_RUN;
        end
      end
      ST_WAIT: if (wake) nxt = ST_RUN;
      ST_RUN: begin
        if (mode == MODE_BUSY && busy_end) begin
          finish = 1'b1;
          nxt    = ST_IDLE;
        end else if (data_mode && !stream && blk_done) begin
          blk_step = 1'b1;
          if (last_blk) begin
            finish = 1'b1;
            nxt    = ST_IDLE;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
    if (abort) begin
      nxt      = ST_IDLE;
      finish   = 1'b0;
      blk_step = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/sdseq_blkcnt.sv
module sdseq_blkcnt #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] init,
  input  logic         step,
  output logic [W-1:0] left,
  output logic         last
);
  localparam logic [W-1:0] ONE = W'(1);

  assign last = (left == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)    left <= '0;
    else if (load) left <= init;
    else if (step) left <= left - ONE;
  end
endmodule

// File: rtl/sdseq_irq.sv
module sdseq_irq #(
  parameter int SHORT = 2,
  parameter int LONG  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic finish,
  input  logic ext,
  output logic done,
  output logic irq
);
  localparam int MAXLEN = (LONG > SHORT) ? LONG : SHORT;
  localparam int IW     = $clog2(MAXLEN + 1);
  localparam logic [IW-1:0] L_SHORT = IW'(SHORT);
  localparam logic [IW-1:0] L_LONG  = IW'(LONG);

  logic [IW-1:0] remain;

  assign irq = (remain != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
      done   <= 1'b0;
    end else begin
      done <= finish;
      if (finish)   remain <= ext ? L_LONG : L_SHORT;
      else if (irq) remain <= remain - IW'(1);
    end
  end
endmodule

// File: rtl/sd_data_seq.sv
module sd_data_seq
  import sdseq_pkg::*;
#(
  parameter int IRQ_SHORT = 2,
  parameter int IRQ_LONG  = 6,
  parameter int LANES     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  input  logic              cmd_sent,
  input  logic              rsp_rcvd,
  input  logic              blk_done,
  input  logic              busy_end,
  output logic              busy_act,
  output logic              rx_act,
  output logic              tx_act,
  output logic [LANES-1:0]  lane_en,
  output logic [1:0]        xfer_size,
  output logic              burst4_req_en,
  output logic [CNT_W-1:0]  blk_left,
  output logic              done,
  output logic              irq
);
  mode_e            cur_mode;
  cfg_t             cfg;
  logic [CNT_W-1:0] cnt_init;
  logic             start_q, abort, launch, finish, blk_step, last_blk;
  logic             running, st_wait;
  state_e           state;

  sdseq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata),
    .fsm_idle(state == ST_IDLE), .mode(cur_mode), .cfg(cfg),
    .cnt_init(cnt_init), .start_q(start_q), .abort(abort), .rdata(reg_rdata)
  );

  sdseq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_q(start_q), .abort(abort),
    .mode(cur_mode), .stream(cfg.stream), .hold(wait_needed(cur_mode, cfg)),
    .cnt_zero(cnt_init == '0), .last_blk(last_blk), .cmd_sent(cmd_sent),
    .rsp_rcvd(rsp_rcvd), .blk_done(blk_done), .busy_end(busy_end),
    .state(state), .launch(launch), .finish(finish), .blk_step(blk_step)
  );

  sdseq_blkcnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(launch), .init(cnt_init),
    .step(blk_step), .left(blk_left), .last(last_blk)
  );

  sdseq_irq #(.SHORT(IRQ_SHORT), .LONG(IRQ_LONG)) u_irq (
    .clk(clk), .rst_n(rst_n), .finish(finish), .ext(cfg.irq_ext),
    .done(done), .irq(irq)
  );

  assign running  = (state == ST_RUN);
  assign st_wait  = (state == ST_WAIT);
  assign busy_act = running && (cur_mode == MODE_BUSY);
  assign rx_act   = running && (cur_mode == MODE_RX);
  assign tx_act   = running && (cur_mode == MODE_TX);

  assign xfer_size     = cfg.size;
  assign burst4_req_en = cfg.burst && (cfg.size == SZ_WORD);

  // Lane 0 always drives; the rest follow the wide-bus bit.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_base
      assign lane_en[g] = 1'b1;
    end else begin : g_wide
      assign lane_en[g] = cfg.wide;
    end
  end
endmodule

// File: rtl/sd_data_seq_chk.sv
module sd_data_seq_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [23:0]      reg_wdata,
  input logic             start_q,
  input logic             st_wait,
  input logic [1:0]       cur_mode,
  input logic             cmd_sent,
  input logic             rsp_rcvd,
  input logic             blk_done,
  input logic             launch,
  input logic             busy_act,
  input logic             rx_act,
  input logic             tx_act,
  input logic [LANES-1:0] lane_en,
  input logic [1:0]       xfer_size,
  input logic             burst4_req_en,
  input logic [11:0]      blk_left,
  input logic             done,
  input logic             irq
);
  p_start_selfclear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);

  p_one_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy_act, rx_act, tx_act}));

  p_rx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wait && cur_mode == 2'b10 && !cmd_sent && !reg_we) |=> !rx_act);

  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wait && cur_mode == 2'b01 && !cmd_sent && !reg_we) |=> !busy_act);

  p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wait && cur_mode == 2'b11 && !rsp_rcvd && !reg_we) |=> !tx_act);

  p_cnt_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!launch && !blk_done) |=> $stable(blk_left));

  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_wdata[1:0] == 2'b00) |=> (!busy_act && !rx_act && !tx_act && !done));

  p_lane0_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lane_en[0]);

  p_burst_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
    burst4_req_en |-> (xfer_size == 2'b10));

  p_done_irq_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> irq);

  p_irq_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !done) |-> $past(irq));
endmodule

bind sd_data_seq sd_data_seq_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
  .start_q(start_q), .st_wait(st_wait), .cur_mode(cur_mode),
  .cmd_sent(cmd_sent), .rsp_rcvd(rsp_rcvd), .blk_done(blk_done),
  .launch(launch), .busy_act(busy_act), .rx_act(rx_act), .tx_act(tx_act),
  .lane_en(lane_en), .xfer_size(xfer_size), .burst4_req_en(burst4_req_en),
  .blk_left(blk_left), .done(done), .irq(irq)
);

// File: tb/sd_data_seq_tb.sv
module sd_data_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [23:0] reg_wdata = '0;
  logic [23:0] reg_rdata;
  logic        cmd_sent = 1'b0, rsp_rcvd = 1'b0, blk_done = 1'b0, busy_end = 1'b0;
  logic        busy_act, rx_act, tx_act, burst4_req_en, done, irq;
  logic [3:0]  lane_en;
  logic [1:0]  xfer_size;
  logic [11:0] blk_left;

  int total = 0;
  int bad = 0;
  bit fin = 1'b0;

  always #10 clk = ~clk;

  sd_data_seq u_dut (.*);

  // {op[1:0], wait option, count[3:0]}
  localparam logic [6:0] VEC [0:5] = '{
    7'b10_0_0010, 7'b10_1_0001, 7'b11_0_0011,
    7'b11_1_0010, 7'b01_0_0000, 7'b01_1_0000
  };

  function automatic logic [23:0] mk(input logic [1:0] md, input logic st,
      input logic sm, input logic wd, input logic wrx, input logic wbs,
      input logic wtx, input logic [1:0] sz, input logic bu, input logic ix,
      input logic [11:0] n);
    return {n, ix, bu, sz, wtx, wbs, wrx, wd, sm, st, md};
  endfunction

  function automatic logic [2:0] exp_act(input logic [1:0] md);
    case (md)
      2'b01:   return 3'b100;
      2'b10:   return 3'b010;
      2'b11:   return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [23:0] d);
    reg_we = 1'b1; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  // 0 cmd_sent, 1 rsp_rcvd, 2 blk_done, 3 busy_end
  task automatic pulse(input int which);
    case (which)
      0: cmd_sent = 1'b1;
      1: rsp_rcvd = 1'b1;
      2: blk_done = 1'b1;
      default: busy_end = 1'b1;
    endcase
    tick();
    cmd_sent = 1'b0; rsp_rcvd = 1'b0; blk_done = 1'b0; busy_end = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [1:0] md;
    logic       w;
    logic [3:0] n;
    int         cnt;

    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check("R1 strobes", {busy_act, rx_act, tx_act, done, irq, burst4_req_en}, 0);
    check("R1 blk_left", blk_left, 0);
    check("R1 rdata", reg_rdata, 0);

    // table walk
    for (int i = 0; i < 6; i++) begin
      md = VEC[i][6:5]; w = VEC[i][4]; n = VEC[i][3:0];
      wr(mk(md, 1'b1, 1'b0, 1'b0, w && md == 2'b10, w && md == 2'b01,
            w && md == 2'b11, 2'b10, 1'b0, 1'b0, 12'(n)));
      check("R2 launch bit high", reg_rdata[2], 1'b1);
      tick();
      check("R2 launch bit cleared", reg_rdata[2], 1'b0);
      if (w) begin
        check("R4 R5 R6 parked", {busy_act, rx_act, tx_act}, 3'b000);
        pulse(md == 2'b11 ? 0 : 1);
        check("R4 R6 wrong event ignored", {busy_act, rx_act, tx_act}, 3'b000);
        pulse(md == 2'b11 ? 1 : 0);
      end
      check("R3 active strobe", {busy_act, rx_act, tx_act}, exp_act(md));
      if (md == 2'b01) begin
        pulse(3);
        check("R14 busy end done", {done, busy_act}, 2'b10);
      end else begin
        check("R7 loaded", blk_left, 12'(n));
        for (int k = 1; k < int'(n); k++) begin
          pulse(2);
          check("R7 count down", blk_left, 12'(int'(n) - k));
          check("R7 no early done", done, 1'b0);
        end
        pulse(2);
        check("R7 last block done", {done, rx_act, tx_act}, 3'b100);
        check("R7 count zero", blk_left, 0);
      end
      check("R12 irq with done", irq, 1'b1);
      tick();
      check("R12 short irq second cycle", {done, irq}, 2'b01);
      tick();
      check("R12 short irq ends", irq, 1'b0);
    end

    // R11 size normalisation and burst gating
    wr(mk(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, 1'b0, 12'd0));
    check("R11 reserved size", xfer_size, 2'b00);
    check("R11 reserved size readback", reg_rdata[9:8], 2'b00);
    check("R11 burst off byte", burst4_req_en, 1'b0);
    wr(mk(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 1'b1, 1'b0, 12'd0));
    check("R11 burst off halfword", burst4_req_en, 1'b0);
    wr(mk(2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b10, 1'b1, 1'b0, 12'd0));
    check("R11 burst on word", burst4_req_en, 1'b1);
    check("R10 wide lanes", lane_en, 4'hF);
    wr(mk(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 12'd0));
    check("R10 narrow lanes", lane_en, 4'h1);

    // R8 stream, R13 ignored write, R9 abort
    wr(mk(2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 12'd3));
    tick();
    check("R8 stream running", rx_act, 1'b1);
    for (int k = 0; k < 3; k++) pulse(2);
    check("R8 stream count held", blk_left, 12'd3);
    check("R8 stream still running", {rx_act, done}, 2'b10);
    wr(mk(2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 12'd5));
    tick();
    check("R13 strobes unchanged", {busy_act, rx_act, tx_act}, 3'b010);
    check("R13 size unchanged", xfer_size, 2'b10);
    check("R13 lanes unchanged", lane_en, 4'h1);
    check("R13 op unchanged", reg_rdata[1:0], 2'b10);
    wr(mk(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 12'd0));
    check("R9 abort idle", {busy_act, rx_act, tx_act, done, irq}, 0);

    // R7 zero count
    wr(mk(2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 12'd0));
    tick();
    check("R7 zero count done", {done, tx_act}, 2'b10);
    repeat (3) tick();

    // R12 long interrupt
    wr(mk(2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b1, 12'd1));
    tick();
    pulse(2);
    check("R12 long done", done, 1'b1);
    cnt = 0;
    while (irq && cnt < 20) begin
      cnt++;
      tick();
    end
    check("R12 long irq length", cnt, 6);

    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule